// File: doc/BRIEF.md
# Change-Event FIFO with Interrupt Status

This block collects change events from control/indication and signalling channels. Each event arrives as a one-cycle push strobe carrying a 5-bit time-slot number. The events are kept in a small first-in first-out store. A live status bit reports whether any event is waiting, and an active-low interrupt pin follows that bit unless software masks it.

Software works the block through a four-register byte interface:
- The status register gives the event-pending bit (bit 7) and a sticky overflow bit (bit 6).
- The data register returns the oldest entry and removes it.
- The mask register holds the pin mask in bit 7.
- The command register has a flush bit (bit 0) that empties the store.

Reading the status register never clears anything. The pending bit falls only when the store runs empty, either by draining it or by a flush.

Reads are registered. `cpu_rdata` carries the value on the cycle after `cpu_rd`. It reads as 0 on any cycle that follows no read. The status output and the pin change on the same clock edge that changes the store or the mask.

Top module: `chg_evt_irq`

## Requirements
- R1: After synchronous reset: the store is empty, `sig_irq_sts` is 0, `irq_n` is 1, the mask and overflow are 0, and `cpu_rdata` is 0.
- R2: `sig_irq_sts`, and bit 7 of the status register (address 0), are 1 exactly when the store holds at least one entry.
- R3: Reading the status register (address 0) changes neither the store, the pending bit nor the overflow bit. Repeated reads return the same value.
- R4: A read of address 1 removes the oldest entry and returns it in arrival order as bit 7 = 1 (valid), bits 6:5 = 0 and bits 4:0 = slot. A read of address 1 on an empty store returns 0 and has no effect.
- R5: The pending bit returns to 0 on the edge that removes the last entry.
- R6: Writing address 3 with bit 0 set empties the store and clears overflow within one cycle. A push in the same cycle is discarded. Address 3 always reads 0, because the command self-clears.
- R7: Bit 7 of address 2 is the mask. `irq_n` is the inverse of (pending AND NOT mask). The mask never alters the pending bit.
- R8: The store holds 16 entries. A push into a full store is dropped and sets overflow (status bit 6). Overflow stays set until a flush.
- R9: A push and a pop in the same cycle both take effect, even when the store is full. In that case no overflow is raised.
- R10: `cpu_rdata` reflects the state before the read edge. It is presented one cycle after `cpu_rd` and is 0 on cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_push | input | 1 | Change event strobe |
| evt_slot | input | 5 | Time-slot number of the event |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| sig_irq_sts | output | 1 | Live event-pending status |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
Two pairs of operations can coincide in one cycle:
- An event push with a data-register pop. This is provoked with the store near-empty and with it full. It is judged by whether the count is held and no overflow appears.
- An event push with a flush command. This is judged by the store reading empty with the pending bit low on the next edge.

A queue-based reference model, stepped on every clock, predicts the status bit, the pin and every read byte. A long pseudo-random phase mixes all the operations so that these collisions recur.

// File: rtl/chg_evt_pkg.sv
package chg_evt_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd3;
  localparam int BIT_PEND  = 7;
  localparam int BIT_OVF   = 6;
  localparam int BIT_VLD   = 7;
  localparam int BIT_MASK  = 7;
  localparam int BIT_FLUSH = 0;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_BYTE  = 2'd1,
    SEL_ENTRY = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/chg_evt_fifo.sv
module chg_evt_fifo #(
  parameter int DEPTH  = 16,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [SLOT_W-1:0] head_slot_o,
  output logic              head_vld_o,
  output logic              nonempty_o,
  output logic              nonempty_nxt_o,
  output logic              ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [SLOT_W:0]   mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              ovf_q, ovf_nxt;
  logic [SLOT_W:0]   head_q;
  logic              full, empty, do_pop, do_push, ovf_set;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (cnt == CNT_FULL);
  assign empty = (cnt == '0);

  always_comb begin
    do_pop  = pop_i && !empty && !flush_i;
    do_push = push_i && (!full || do_pop) && !flush_i;
    ovf_set = push_i && full && !do_pop && !flush_i;
    if (flush_i) begin
      cnt_nxt = '0;
      ovf_nxt = 1'b0;
    end else begin
      ovf_nxt = ovf_q | ovf_set;
      case ({do_push, do_pop})
        2'b10:   cnt_nxt = cnt + CNT_W'(1);
        2'b01:   cnt_nxt = cnt - CNT_W'(1);
        default: cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      ovf_q <= ovf_nxt;
      if (flush_i) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (do_push) wr_ptr <= ptr_inc(wr_ptr);
        if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      end
    end
  end

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {1'b1, slot_i};
  end

  always_ff @(posedge clk) begin
    head_q <= mem[rd_ptr];
  end

  assign head_slot_o    = head_q[SLOT_W-1:0];
  assign head_vld_o     = head_q[SLOT_W];
  assign nonempty_o     = !empty;
  assign nonempty_nxt_o = (cnt_nxt != '0);
  assign ovf_o          = ovf_q;

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);
  a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && !pop_i && !flush_i) |=> (full && ovf_q));
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (empty && !ovf_q));
  a_r9_full_push_pop: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && pop_i && !flush_i) |=> (full && $stable(ovf_q)));
endmodule

// File: rtl/chg_evt_regif.sv
module chg_evt_regif
  import chg_evt_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              nonempty_i,
  input  logic              ovf_i,
  input  logic [SLOT_W-1:0] head_slot_i,
  input  logic              head_vld_i,
  output logic              pop_o,
  output logic              flush_o,
  output logic              mask_nxt_o
);
  rd_sel_e           sel_q;
  logic [DATA_W-1:0] byte_q;
  logic              ent_vld_q;
  logic              mask_q;
  logic [DATA_W-1:0] stat_byte, mask_byte, entry_byte;

  assign pop_o      = cpu_rd && (cpu_addr == A_DATA);
  assign flush_o    = cpu_wr && (cpu_addr == A_CMD) && cpu_wdata[BIT_FLUSH];
  assign mask_nxt_o = (cpu_wr && (cpu_addr == A_MASK)) ? cpu_wdata[BIT_MASK] : mask_q;

  always_comb begin
    stat_byte           = '0;
    stat_byte[BIT_PEND] = nonempty_i;
    stat_byte[BIT_OVF]  = ovf_i;
    mask_byte           = '0;
    mask_byte[BIT_MASK] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= 1'b0;
      sel_q     <= SEL_NONE;
      byte_q    <= '0;
      ent_vld_q <= 1'b0;
    end else begin
      mask_q    <= mask_nxt_o;
      sel_q     <= SEL_NONE;
      byte_q    <= '0;
      ent_vld_q <= 1'b0;
      if (cpu_rd) begin
        case (cpu_addr)
          A_STAT: begin sel_q <= SEL_BYTE;  byte_q <= stat_byte; end
          A_MASK: begin sel_q <= SEL_BYTE;  byte_q <= mask_byte; end
          A_DATA: begin sel_q <= SEL_ENTRY; ent_vld_q <= nonempty_i; end
          default: sel_q <= SEL_BYTE;
        endcase
      end
    end
  end

  always_comb begin
    entry_byte = '0;
    if (ent_vld_q) begin
      entry_byte[BIT_VLD]      = head_vld_i;
      entry_byte[SLOT_W-1:0]   = head_slot_i;
    end
    case (sel_q)
      SEL_BYTE:  cpu_rdata = byte_q;
      SEL_ENTRY: cpu_rdata = entry_byte;
      default:   cpu_rdata = '0;
    endcase
  end

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == A_MASK) |=> (mask_q == $past(mask_q)));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (cpu_rdata == '0));
endmodule

// File: rtl/chg_evt_irqgen.sv
module chg_evt_irqgen (
  input  logic clk,
  input  logic rst,
  input  logic pend_nxt_i,
  input  logic mask_nxt_i,
  output logic pend_o,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      pend_o  <= pend_nxt_i;
      irq_n_o <= !(pend_nxt_i && !mask_nxt_i);
    end
  end

  a_r7_pin_needs_status: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> pend_o);
endmodule

// File: rtl/chg_evt_irq.sv
module chg_evt_irq
  import chg_evt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_push,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              sig_irq_sts,
  output logic              irq_n
);
  logic [SLOT_W-1:0] head_slot;
  logic head_vld, nonempty, nonempty_nxt, ovf, pop, flush, mask_nxt;

  chg_evt_fifo #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_fifo (
    .clk(clk), .rst(rst), .push_i(evt_push), .slot_i(evt_slot),
    .pop_i(pop), .flush_i(flush), .head_slot_o(head_slot),
    .head_vld_o(head_vld), .nonempty_o(nonempty),
    .nonempty_nxt_o(nonempty_nxt), .ovf_o(ovf)
  );

  chg_evt_regif #(.SLOT_W(SLOT_W)) u_regif (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .nonempty_i(nonempty), .ovf_i(ovf), .head_slot_i(head_slot),
    .head_vld_i(head_vld), .pop_o(pop), .flush_o(flush),
    .mask_nxt_o(mask_nxt)
  );

  chg_evt_irqgen u_irq (
    .clk(clk), .rst(rst), .pend_nxt_i(nonempty_nxt),
    .mask_nxt_i(mask_nxt), .pend_o(sig_irq_sts), .irq_n_o(irq_n)
  );

  a_r2_status_matches_fill: assert property (@(posedge clk) disable iff (rst)
    sig_irq_sts == nonempty);
  a_r3_stat_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == A_STAT && !cpu_wr && !evt_push) |=> $stable(sig_irq_sts));
endmodule

// File: tb/chg_evt_irq_test.sv
module chg_evt_irq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_push = 1'b0;
  logic [4:0] evt_slot = '0;
  logic [1:0] cpu_addr = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic sig_irq_sts, irq_n;

  int total = 0, bad = 0;
  int q[$];
  bit m_mask = 0, m_ovf = 0;

  always #4 clk = ~clk;

  chg_evt_irq uut (
    .clk(clk), .rst(rst), .evt_push(evt_push), .evt_slot(evt_slot),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sig_irq_sts(sig_irq_sts), .irq_n(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, step model, compare at the falling edge
  task automatic cyc(input bit push, input int slot, input bit rd, input bit wr,
                     input int addr, input int wdata, input string tag);
    int exp_rd;
    bit flush, popok;
    evt_push = push; evt_slot = 5'(slot); cpu_rd = rd; cpu_wr = wr;
    cpu_addr = 2'(addr); cpu_wdata = 8'(wdata);
    exp_rd = 0;
    if (rd) begin
      case (addr)
        0: exp_rd = ((q.size() > 0) ? 8'h80 : 0) | (m_ovf ? 8'h40 : 0);
        1: exp_rd = (q.size() > 0) ? (8'h80 | q[0]) : 0;
        2: exp_rd = m_mask ? 8'h80 : 0;
        default: exp_rd = 0;
      endcase
    end
    flush = wr && addr == 3 && wdata[0];
    @(posedge clk);
    if (wr && addr == 2) m_mask = wdata[7];
    if (flush) begin
      q.delete();
      m_ovf = 0;
    end else begin
      popok = rd && addr == 1 && q.size() > 0;
      if (popok) void'(q.pop_front());
      if (push) begin
        if (q.size() < 16) q.push_back(slot & 31);
        else m_ovf = 1;
      end
    end
    @(negedge clk);
    check({tag, " R2 status"}, sig_irq_sts, q.size() > 0);
    check({tag, " R7 pin"}, irq_n, !(q.size() > 0 && !m_mask));
    check({tag, " R10 rdata"}, cpu_rdata, exp_rd);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, "idle"); endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 status", sig_irq_sts, 0);
    check("R1 pin", irq_n, 1);
    check("R1 rdata", cpu_rdata, 0);
    cyc(0, 0, 1, 0, 0, 0, "R1 stat");
    cyc(0, 0, 1, 0, 2, 0, "R1 mask");
    // R2/R3 pending level, repeated status reads
    cyc(1, 3, 0, 0, 0, 0, "R2");
    cyc(1, 17, 0, 0, 0, 0, "R2");
    cyc(1, 31, 1, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, "R3");
    // R4/R5 drain in order, then empty read
    cyc(0, 0, 1, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, 1, 0, "R5");
    cyc(0, 0, 1, 0, 1, 0, "R4 empty");
    cyc(0, 0, 1, 0, 0, 0, "R5 stat");
    // R7 mask
    cyc(0, 0, 0, 1, 2, 8'h80, "R7");
    cyc(1, 9, 0, 0, 0, 0, "R7 masked");
    cyc(0, 0, 1, 0, 0, 0, "R7 stat");
    cyc(0, 0, 1, 1, 2, 0, "R7 unmask");
    cyc(0, 0, 1, 0, 1, 0, "R4");
    // R9 push+pop with a single entry
    cyc(1, 5, 0, 0, 0, 0, "R9");
    cyc(1, 6, 1, 0, 1, 0, "R9");
    cyc(0, 0, 1, 0, 1, 0, "R9");
    // R8 fill past depth
    for (int i = 0; i < 18; i++) cyc(1, i + 10, 0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, "R8 ovf");
    // R9 push+pop on full store
    cyc(1, 2, 1, 0, 1, 0, "R9 full");
    cyc(0, 0, 1, 0, 0, 0, "R9 stat");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 1, 0, "R4 order");
    cyc(0, 0, 1, 0, 0, 0, "R8 sticky");
    // R6 flush, with push collision, command reads 0
    cyc(1, 4, 0, 1, 3, 1, "R6 flush+push");
    cyc(0, 0, 1, 0, 0, 0, "R6 stat");
    cyc(0, 0, 1, 0, 3, 0, "R6 cmd");
    cyc(0, 0, 1, 0, 1, 0, "R6 empty");
    // pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 31), r < 45, r >= 45 && r < 52,
          (r >= 45 && r < 52) ? ((r == 51) ? 3 : 2) : $urandom_range(0, 3),
          $urandom_range(0, 255), "mix");
    end
    repeat (2) idle();
    finish_run();
  end
endmodule